// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Timer

A single down-counting timer channel that a processor programs through a write strobe with a one-bit address and a data word. A mode register picks one of five behaviours for the shared counter: a terminal-count interrupt, a gate-triggered one-shot, a periodic rate pulse, a strobe started by writing the count, and a strobe started by a rising edge on the gate input. The counter advances only on clock edges where the `tick` enable is high, which stands for the gated counting clock.

The block has no separate interrupt output. The single `out` pin carries the waveform of the selected mode, and that pin is also the interrupt request. In terminal-count mode the high level on `out` is the request, and it stays high until software writes the mode or the count again.

The write port is a plain register strobe, not a stream. It has no ready signal, applies no back-pressure and accepts a write on every clock edge where `wr_en` is high. A mode write at address 0 takes `wr_data[2:0]` as the mode code. A count write at address 1 takes the full `wr_data` word as the count.

Top module: `pit_timer`

## Requirements
- R1: Right after reset `out` is high and the timer is idle. With `tick` and `gate` high and no write, `out` stays high.
- R2: A write with `wr_addr`=0 selects the mode from `wr_data[2:0]`: 0 terminal-count interrupt, 1 one-shot, 2 rate pulse, 3 software strobe, 4 hardware strobe. The write stops the counter. It drives `out` low on the next edge for code 0 and high for codes 1 to 4. Codes 5 to 7 are ignored and leave the current mode in force.
- R3: In mode 0, a count write of N drives `out` low on the next edge. `out` goes high after N counted ticks and then stays high (the interrupt request) until the next write.
- R4: In mode 1, a rising edge on `gate` drives `out` low on the next edge and loads the count. `out` stays low for N counted ticks and then returns high. A further rising edge while `out` is low reloads the count and restarts the pulse.
- R5: In mode 2, a count write of N (N at least 2) starts a periodic output. The counter reloads itself at terminal count, and `out` goes low for exactly one clock every N counted ticks.
- R6: In mode 3, a count write of N starts the count. After N counted ticks `out` goes low for exactly one clock, then stays high. The strobe does not repeat.
- R7: In mode 4, a rising edge on `gate` starts a count of N. After N counted ticks `out` goes low for exactly one clock, then stays high.
- R8: The counter moves only on edges with `tick` high. In modes 0, 2 and 3 a low level on `gate` also holds the count.
- R9: A count value of 0 stands for 2^16 counted ticks.
- R10: In modes 1 and 4 a count write only stores the count. Nothing starts until a rising edge on `gate`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the mode register, 1 the count register |
| wr_data | input | 16 | Write data: mode code in bits 2:0, or the count |
| gate | input | 1 | Gate level (pause in modes 0/2/3) and trigger edge (modes 1/4) |
| tick | input | 1 | Count enable, one counted tick per edge where it is high |
| out | output | 1 | Mode waveform, also the interrupt request |

## Verification
The situation hardest to reach from the ports is a retrigger in one-shot mode. A second rising edge on `gate` has to land while the pulse is still running, and a falling edge must come between the two rising edges. The stimulus starts a pulse and then lowers and raises `gate` on the next two cycles. It then checks that the low time is measured from the second edge rather than the first. The zero count, which means the full 2^16 range, is reached simply by running a full-length count. The pause conditions are reached by holding `tick` or `gate` low for a stretch while the counter is loaded, and confirming that `out` does not change.

// File: rtl/pit_pkg.sv
package pit_pkg;

  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_TCINT   = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SWSTB   = 3'd3,
    MD_HWSTB   = 3'd4
  } pit_mode_e;

  localparam logic ADDR_MODE  = 1'b0;
  localparam logic ADDR_COUNT = 1'b1;

  function automatic logic mode_legal(input logic [MODE_W-1:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic mode_self_start(input pit_mode_e m);
    return (m == MD_TCINT) || (m == MD_RATE) || (m == MD_SWSTB);
  endfunction

  function automatic logic mode_gate_trig(input pit_mode_e m);
    return (m == MD_ONESHOT) || (m == MD_HWSTB);
  endfunction

endpackage

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output pit_mode_e        mode_q,
  output pit_mode_e        mode_new,
  output logic             mode_wr,
  output logic             cnt_wr,
  output logic [CNT_W:0]   load_val,
  output logic [CNT_W:0]   reload_q
);

  localparam logic [CNT_W:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};

  assign mode_new = pit_mode_e'(wr_data[MODE_W-1:0]);
  assign mode_wr  = wr_en && (wr_addr == ADDR_MODE) && mode_legal(wr_data[MODE_W-1:0]);
  assign cnt_wr   = wr_en && (wr_addr == ADDR_COUNT);
  assign load_val = (wr_data == '0) ? FULL_RANGE : {1'b0, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_TCINT;
      reload_q <= FULL_RANGE;
    end else begin
      if (mode_wr) mode_q <= mode_new;
      if (cnt_wr)  reload_q <= load_val;
    end
  end

endmodule

// File: rtl/pit_trigger.sv
module pit_trigger #(
  parameter int SYNC_STG = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_lvl,
  output logic gate_rise
);

  logic gate_q;

  generate
    if (SYNC_STG == 0) begin : g_direct
      assign gate_lvl = gate;
    end else begin : g_sync
      logic [SYNC_STG-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STG-2:0], gate};
      end
      assign gate_lvl = sync_q[SYNC_STG-1];
    end
  endgenerate

  // Reset to high so a gate already high at reset release is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b1;
    else        gate_q <= gate_lvl;
  end

  assign gate_rise = gate_lvl && !gate_q;

endmodule

// File: rtl/pit_core.sv
module pit_core
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pit_mode_e      mode_q,
  input  pit_mode_e      mode_new,
  input  logic           mode_wr,
  input  logic           cnt_wr,
  input  logic [CNT_W:0] load_val,
  input  logic [CNT_W:0] reload_q,
  input  logic           tick,
  input  logic           gate_lvl,
  input  logic           gate_rise,
  output logic [CNT_W:0] cnt_q,
  output logic           running,
  output logic           out
);

  localparam logic [CNT_W:0] ONE = {{CNT_W{1'b0}}, 1'b1};

  logic advance;
  logic expire;
  logic trig;

  assign trig    = gate_rise && mode_gate_trig(mode_q);
  assign advance = running && tick && (gate_lvl || mode_gate_trig(mode_q));
  assign expire  = advance && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      running <= 1'b0;
      out     <= 1'b1;
    end else if (mode_wr) begin
      running <= 1'b0;
      out     <= (mode_new != MD_TCINT);
    end else if (cnt_wr && mode_self_start(mode_q)) begin
      cnt_q   <= load_val;
      running <= 1'b1;
      out     <= (mode_q != MD_TCINT);
    end else if (trig) begin
      cnt_q   <= reload_q;
      running <= 1'b1;
      out     <= (mode_q != MD_ONESHOT);
    end else if (expire) begin
      unique case (mode_q)
        MD_TCINT, MD_ONESHOT: begin
          out     <= 1'b1;
          running <= 1'b0;
          cnt_q   <= '0;
        end
        MD_RATE: begin
          out   <= 1'b0;
          cnt_q <= reload_q;
        end
        default: begin
          out     <= 1'b0;
          running <= 1'b0;
          cnt_q   <= '0;
        end
      endcase
    end else begin
      if (advance) cnt_q <= cnt_q - ONE;
      if (!out && (mode_q inside {MD_RATE, MD_SWSTB, MD_HWSTB})) out <= 1'b1;
    end
  end

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int SYNC_STG = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             gate,
  input  logic             tick,
  output logic             out
);

  pit_mode_e      mode_q;
  pit_mode_e      mode_new;
  logic           mode_wr;
  logic           cnt_wr;
  logic [CNT_W:0] load_val;
  logic [CNT_W:0] reload_q;
  logic           gate_lvl;
  logic           trig;
  logic [CNT_W:0] cnt_q;
  logic           running;

  pit_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode_q   (mode_q),
    .mode_new (mode_new),
    .mode_wr  (mode_wr),
    .cnt_wr   (cnt_wr),
    .load_val (load_val),
    .reload_q (reload_q)
  );

  pit_trigger #(.SYNC_STG(SYNC_STG)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .gate_lvl  (gate_lvl),
    .gate_rise (trig)
  );

  pit_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .mode_new  (mode_new),
    .mode_wr   (mode_wr),
    .cnt_wr    (cnt_wr),
    .load_val  (load_val),
    .reload_q  (reload_q),
    .tick      (tick),
    .gate_lvl  (gate_lvl),
    .gate_rise (trig),
    .cnt_q     (cnt_q),
    .running   (running),
    .out       (out)
  );

endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             tick,
  input logic             out,
  input pit_mode_e        mode_q,
  input logic [CNT_W:0]   cnt_q,
  input logic             running,
  input logic             trig
);

  localparam logic [CNT_W:0] FULL_RANGE = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] ONE        = {{CNT_W{1'b0}}, 1'b1};

  // R2: a mode write of code 0 leaves out low, codes 1..4 leave it high
  a_r2_mode0_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 1'b0 && wr_data[2:0] == 3'd0) |=> !out);
  a_r2_other_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 1'b0 && wr_data[2:0] != 3'd0 && wr_data[2:0] <= 3'd4) |=> out);

  // R3: count write in mode 0 clears the request; request then stays set
  a_r3_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TCINT && wr_en && wr_addr == 1'b1) |=> !out);
  a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_TCINT && out && !wr_en) |=> out);

  // R4: one-shot pulse is low for as long as the counter runs
  a_r4_oneshot_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT && running) |-> !out);

  // R5, R6, R7: pulse and strobe modes drive out low for one clock only
  a_r5_r6_r7_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {MD_RATE, MD_SWSTB, MD_HWSTB} && !out && !wr_en &&
     !(mode_q == MD_RATE && cnt_q == ONE)) |=> out);

  // R8: no tick, no write, no trigger: counter holds
  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en && !trig) |=> $stable(cnt_q));

  // R9: counter never exceeds the full 2^CNT_W range
  a_r9_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_RANGE);

  // R10: count write in a gate-triggered mode does not start the counter
  a_r10_wait_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q inside {MD_ONESHOT, MD_HWSTB} && !running && !trig &&
     wr_en && wr_addr == 1'b1) |=> !running);

endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .tick    (tick),
  .out     (out),
  .mode_q  (mode_q),
  .cnt_q   (cnt_q),
  .running (running),
  .trig    (trig)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        gate = 1'b1;
  logic        tick = 1'b1;
  logic        out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pit_timer u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .gate    (gate),
    .tick    (tick),
    .out     (out)
  );

  typedef struct packed {
    logic [2:0]  md;
    logic [15:0] n;
    int          first;
    int          len;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 16'd5, 0, 5},
    '{3'd0, 16'd1, 0, 1},
    '{3'd1, 16'd4, 0, 4},
    '{3'd1, 16'd1, 0, 1},
    '{3'd2, 16'd3, 3, 1},
    '{3'd2, 16'd7, 7, 1},
    '{3'd3, 16'd6, 6, 1},
    '{3'd3, 16'd2, 2, 1},
    '{3'd4, 16'd5, 5, 1},
    '{3'd4, 16'd3, 3, 1},
    '{3'd2, 16'd2, 2, 1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive at a falling edge, return at the falling edge after the write edge.
  task automatic wr(input logic a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic trigger();
    gate = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Sample index of first low and length of that low run.
  task automatic measure(input int limit, output int first, output int len);
    first = -1; len = 0;
    for (int i = 0; i < limit; i++) begin
      if (!out) begin
        if (first < 0) first = i;
        len++;
      end else if (first >= 0) begin
        break;
      end
      @(negedge clk);
    end
  endtask

  // Number of samples in n cycles where out differs from lvl.
  task automatic stay(input logic lvl, input int n, output int bad);
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (out !== lvl) bad++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int f, l, bad;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out === 1'b1, "R1 out after reset", out, 1);
    rst_n = 1'b1;
    @(negedge clk);
    stay(1'b1, 20, bad);
    check(bad == 0, "R1 idle out stays high", bad, 0);

    // Vector table: mode, count, first low sample, low length
    for (int v = 0; v < NVEC; v++) begin
      logic trg;
      trg = (VECS[v].md == 3'd1) || (VECS[v].md == 3'd4);
      tick = 1'b1;
      gate = trg ? 1'b0 : 1'b1;
      wr(1'b0, {13'd0, VECS[v].md});
      wr(1'b1, VECS[v].n);
      if (trg) trigger();
      measure(200, f, l);
      // R3 R4 R5 R6 R7: waveform by mode
      check(f == VECS[v].first, $sformatf("R3/R4/R5/R6/R7 vec %0d first low", v), f, VECS[v].first);
      check(l == VECS[v].len, $sformatf("R3/R4/R5/R6/R7 vec %0d low length", v), l, VECS[v].len);
    end

    // R5: second period of rate pulse is N counted ticks apart
    gate = 1'b1;
    wr(1'b0, 16'd2);
    wr(1'b1, 16'd4);
    measure(50, f, l);
    measure(50, f, l);
    check(f == 3 && l == 1, "R5 second period", f, 3);

    // R2: writing the mode again stops the counter
    wr(1'b0, 16'd2);
    stay(1'b1, 12, bad);
    check(bad == 0, "R2 mode write stops rate", bad, 0);

    // R2: mode code 0 drives out low
    wr(1'b0, 16'd0);
    check(out === 1'b0, "R2 mode 0 write out low", out, 0);

    // R2: illegal code 5 ignored, mode 3 stays in force
    wr(1'b0, 16'd3);
    wr(1'b0, 16'd5);
    wr(1'b1, 16'd4);
    measure(50, f, l);
    check(f == 4 && l == 1, "R2 illegal mode ignored", f, 4);

    // R6: software strobe does not repeat
    stay(1'b1, 20, bad);
    check(bad == 0, "R6 no repeat", bad, 0);

    // R3: interrupt level sticks
    wr(1'b0, 16'd0);
    wr(1'b1, 16'd3);
    measure(50, f, l);
    stay(1'b1, 20, bad);
    check(bad == 0, "R3 request stays high", bad, 0);

    // R8: tick low holds the count
    tick = 1'b0;
    wr(1'b0, 16'd0);
    wr(1'b1, 16'd3);
    stay(1'b0, 10, bad);
    check(bad == 0, "R8 no tick holds", bad, 0);
    tick = 1'b1;
    measure(50, f, l);
    check(l == 3, "R8 resumes after tick", l, 3);

    // R8: gate low pauses software strobe
    gate = 1'b0;
    wr(1'b0, 16'd3);
    wr(1'b1, 16'd2);
    stay(1'b1, 10, bad);
    check(bad == 0, "R8 gate low pauses", bad, 0);
    gate = 1'b1;
    measure(50, f, l);
    check(f == 2 && l == 1, "R8 resumes after gate", f, 2);

    // R10: count write in hardware strobe mode waits for gate edge
    gate = 1'b0;
    wr(1'b0, 16'd4);
    wr(1'b1, 16'd3);
    stay(1'b1, 10, bad);
    check(bad == 0, "R10 waits for trigger", bad, 0);
    trigger();
    measure(50, f, l);
    check(f == 3 && l == 1, "R10 strobe after trigger", f, 3);

    // R4: retrigger restarts the one-shot
    gate = 1'b0;
    wr(1'b0, 16'd1);
    wr(1'b1, 16'd5);
    trigger();
    gate = 1'b0;
    @(negedge clk);
    gate = 1'b1;
    @(negedge clk);
    measure(50, f, l);
    check(f == 0 && l == 5, "R4 retrigger length", l, 5);

    // R9: zero count means 65536 ticks
    gate = 1'b1;
    wr(1'b0, 16'd0);
    wr(1'b1, 16'd0);
    measure(70000, f, l);
    check(l == 65536, "R9 zero is full range", l, 65536);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule